// File: doc/BRIEF.md
# Unaligned Load/Store Access Unit

This unit sits between a processor's address generation stage and a 32-bit data memory that is addressed by words. Each request is a byte, halfword or word load or store. A request can also carry an access class: single transfer, load/store multiple, doubleword, or exclusive/coprocessor. The non-single classes always count as word-sized. Two configuration inputs choose the alignment policy: a strict-alignment enable and an unaligned-support enable. The unit checks alignment in the cycle it accepts the request. An access that faults returns a fixed alignment status code and never reaches memory.

When unaligned support is off, the unit uses the legacy policy. The memory address is truncated to the natural boundary of the access. A single-word load from an address that is not word-aligned returns the aligned word rotated right by eight bits for each byte of offset. When unaligned support is on and strict checking is off, a single word or halfword access that crosses a word boundary is split into two word transactions. For stores, byte write enables select which bytes each transaction writes. For loads, the bytes from the two reads are joined in little-endian order. Halfword and byte loads can be zero-extended or sign-extended to 32 bits.

Requests use a valid/ready handshake. Ready is high only while the unit is idle. Every request ends with a single-cycle `done` pulse. Memory has a read latency of one cycle and accepts every request.

Top module: `lsu_align_unit`

## Requirements
- R1: With `cfg_strict`=1, these single-class accesses fault: a halfword at an odd address, and a word with address bits [1:0] not 00. A fault is signalled one cycle after acceptance by `done`=1, `fault`=1 and `fault_code`=4'b0001. No `mem_req` is raised for that access.
- R2: With `cfg_unaligned`=1, an access of class multiple (`req_kind`=01), doubleword (10) or exclusive/coprocessor (11) faults whenever address bits [1:0] are not 00, whatever `cfg_strict` is set to. When these classes are word-aligned, or when `cfg_unaligned`=0 and `cfg_strict`=0, they complete as word accesses.
- R3: With `cfg_unaligned`=0, a word load issues one transaction at the address with bits [1:0] cleared. It returns that word rotated right by 8×addr[1:0].
- R4: With `cfg_unaligned`=0, a halfword access uses address bit 1 and ignores address bit 0. It uses the lanes at byte offset {addr[1],0}.
- R5: With `cfg_unaligned`=1 and `cfg_strict`=0, a word or halfword whose bytes cross a word boundary issues exactly two transactions. The first goes to the lower aligned word and the second to the next word. `req_ready` stays low and `done` arrives two cycles after acceptance.
- R6: In a split store, each transaction sets `mem_be` only for its own bytes (bit k enables bits [8k+7:8k]). The data lanes are aligned to the byte address.
- R7: In a split load, the result takes its low bytes from the first word and its high bytes from the second word, in little-endian order.
- R8: For a byte or halfword load, `req_signed`=1 sign-extends the result to 32 bits and `req_signed`=0 zero-extends it.
- R9: An access that does not cross a boundary and does not fault issues one transaction, and `done` follows one cycle after acceptance. `done` lasts one cycle.
- R10: Byte accesses, and accesses aligned to their size, never fault.
- R11: During reset and after reset, `req_ready`=1, `done`=0, `fault`=0 and `mem_req`=0 until a request arrives. `req_size` encodes 00 as byte, 01 as halfword, and 10 or 11 as word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strict | input | 1 | Strict alignment checking enable |
| cfg_unaligned | input | 1 | Unaligned access support enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_kind | input | 2 | Access class code |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req | output | 1 | Memory transaction this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte write enables |
| mem_wdata | output | 32 | Write data, lane-aligned |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Completion is an alignment fault |
| fault_code | output | 4 | Fault status code |
| rdata | output | 32 | Load result, valid with `done` |

## Verification
In the middle cycle of a split load, the unit does two things at once. It issues the upper-word transaction and it captures the lower word returned by the previous read. Loads are aimed across boundaries where the two neighbouring words hold different byte patterns. An error in capture order or timing then shows up as a swapped or repeated byte in the merged result. The bench also counts the transactions issued and measures the latency to `done` against the expected values. A second case is a fault that is decided in the same cycle the request is accepted. The bench confirms that no memory transaction is seen in that cycle and that the fault pulse follows one cycle later.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] KIND_SINGLE = 2'd0;

  localparam logic [3:0] FLT_ALIGN = 4'b0001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SECOND,
    ST_RESP,
    ST_FAULT
  } state_e;

  typedef struct packed {
    logic       fault;
    logic       split;
    logic [1:0] ld_off;
    logic [1:0] st_off;
    logic [3:0] lanes;
  } plan_t;

endpackage

// File: rtl/lsu_align_decode.sv
module lsu_align_decode
  import lsu_align_pkg::*;
(
  input  logic       strict_en,
  input  logic       unal_en,
  input  logic [1:0] size,
  input  logic [1:0] kind,
  input  logic [1:0] off,
  output plan_t      plan
);

  logic       single, is_half, word_like, mis;
  logic [2:0] nbytes, span;

  always_comb begin
    single    = (kind == KIND_SINGLE);
    is_half   = single && (size == SZ_HALF);
    word_like = !single || size[1];
    nbytes    = word_like ? 3'd4 : (is_half ? 3'd2 : 3'd1);
    mis       = word_like ? (off != 2'b00) : (is_half && off[0]);

    plan.fault = mis && (strict_en || (unal_en && !single));

    if (unal_en) begin
      plan.ld_off = off;
      plan.st_off = off;
    end else if (word_like) begin
      plan.ld_off = off;      // legacy rotate on load
      plan.st_off = 2'b00;    // legacy store is not rotated
    end else if (is_half) begin
      plan.ld_off = {off[1], 1'b0};
      plan.st_off = {off[1], 1'b0};
    end else begin
      plan.ld_off = off;
      plan.st_off = off;
    end

    span       = {1'b0, plan.st_off} + nbytes;
    plan.split = unal_en && !plan.fault && (span > 3'd4);
    plan.lanes = word_like ? 4'hF : (is_half ? 4'h3 : 4'h1);
  end

endmodule

// File: rtl/lsu_align_store.sv
module lsu_align_store (
  input  logic [31:0] wdata,
  input  logic [1:0]  off,
  input  logic [3:0]  lanes,
  output logic [63:0] wd_pair,
  output logic [7:0]  be_pair
);

  always_comb begin
    wd_pair = {32'b0, wdata} << {off, 3'b000};
    be_pair = {4'b0, lanes} << off;
  end

endmodule

// File: rtl/lsu_align_load.sv
module lsu_align_load (
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic [1:0]  off,
  input  logic [3:0]  lanes,
  input  logic        sgn,
  output logic [31:0] result
);

  logic [63:0] pair;
  logic [31:0] sh;

  always_comb begin
    pair = {hi_word, lo_word};
    sh   = 32'(pair >> {off, 3'b000});
    unique case (lanes)
      4'h1:    result = {{24{sgn & sh[7]}}, sh[7:0]};
      4'h3:    result = {{16{sgn & sh[15]}}, sh[15:0]};
      default: result = sh;
    endcase
  end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_strict,
  input  logic          cfg_unaligned,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_kind,
  input  logic          req_signed,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          fault,
  output logic [3:0]    fault_code,
  output logic [31:0]   rdata
);

  localparam int WAW = AW - 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  plan_t       plan;
  logic [63:0] wd_pair;
  logic [7:0]  be_pair;
  logic [31:0] ld_word;

  state_e   state_q, state_d;
  logic           wr_q, sgn_q, split_q;
  logic [1:0]     ld_off_q;
  logic [3:0]     lanes_q, be_hi_q;
  logic [31:0]    wd_hi_q, lo_q;
  logic [WAW-1:0] nxt_q;
  logic           accept, hold_en, lo_en;

  lsu_align_decode u_dec (
    .strict_en (cfg_strict),
    .unal_en   (cfg_unaligned),
    .size      (req_size),
    .kind      (req_kind),
    .off       (req_addr[1:0]),
    .plan      (plan)
  );

  lsu_align_store u_st (
    .wdata   (req_wdata),
    .off     (plan.st_off),
    .lanes   (plan.lanes),
    .wd_pair (wd_pair),
    .be_pair (be_pair)
  );

  lsu_align_load u_ld (
    .lo_word (split_q ? lo_q : mem_rdata),
    .hi_word (mem_rdata),
    .off     (ld_off_q),
    .lanes   (lanes_q),
    .sgn     (sgn_q),
    .result  (ld_word)
  );

  // next-state and output logic
  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    accept     = req_valid && req_ready;
    hold_en    = accept;
    lo_en      = (state_q == ST_SECOND);
    state_d    = state_q;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {req_addr[AW-1:2], 2'b00};
    mem_be     = 4'hF;
    mem_wdata  = 32'b0;
    done       = 1'b0;
    fault      = 1'b0;
    fault_code = 4'b0000;
    rdata      = 32'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (plan.fault) begin
            state_d = ST_FAULT;
          end else begin
            state_d   = plan.split ? ST_SECOND : ST_RESP;
            mem_req   = 1'b1;
            mem_we    = req_write;
            mem_be    = req_write ? be_pair[3:0] : 4'hF;
            mem_wdata = wd_pair[31:0];
          end
        end
      end
      ST_SECOND: begin
        state_d   = ST_RESP;
        mem_req   = 1'b1;
        mem_we    = wr_q;
        mem_addr  = {nxt_q, 2'b00};
        mem_be    = wr_q ? be_hi_q : 4'hF;
        mem_wdata = wd_hi_q;
      end
      ST_RESP: begin
        state_d = ST_IDLE;
        done    = 1'b1;
        rdata   = wr_q ? 32'b0 : ld_word;
      end
      default: begin
        state_d    = ST_IDLE;
        done       = 1'b1;
        fault      = 1'b1;
        fault_code = FLT_ALIGN;
      end
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // request hold registers
  always_ff @(posedge clk) begin
    if (hold_en) begin
      wr_q     <= req_write;
      sgn_q    <= req_signed;
      split_q  <= plan.split;
      ld_off_q <= plan.ld_off;
      lanes_q  <= plan.lanes;
      be_hi_q  <= be_pair[7:4];
      wd_hi_q  <= wd_pair[63:32];
      nxt_q    <= req_addr[AW-1:2] + WAW'(1);
    end
  end

  // lower word of a split load
  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= mem_rdata;
  end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_align_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_size,
  input logic [1:0]    req_kind,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          done,
  input logic          fault,
  input logic [3:0]    fault_code
);

  a_r1_no_mem_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req && !$past(mem_req)));

  a_r1_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && fault_code == FLT_ALIGN));

  a_r5_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_ready) |-> (mem_addr == $past(mem_addr) + AW'(4)));

  a_r5_split_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_ready) |=> (done && !req_ready));

  a_r6_store_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'b0000));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == SZ_BYTE && req_kind == KIND_SINGLE) |=> !fault);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |-> !mem_req);

endmodule

bind lsu_align_unit lsu_align_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_kind   (req_kind),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .done       (done),
  .fault      (fault),
  .fault_code (fault_code)
);

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;

  localparam int PERIOD = 10;
  localparam int AW     = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_strict, cfg_unaligned;
  logic          req_valid, req_ready, req_write, req_signed;
  logic [1:0]    req_size, req_kind;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = 32'b0;
  logic          done, fault;
  logic [3:0]    fault_code;
  logic [31:0]   rdata;

  int nchk  = 0;
  int nfail = 0;

  always #(PERIOD/2) clk = ~clk;

  lsu_align_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_strict(cfg_strict), .cfg_unaligned(cfg_unaligned),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_kind(req_kind), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code), .rdata(rdata)
  );

  // memory model: 16 words, request sampled off-edge, applied at the edge
  logic [31:0]   mem [16];
  logic          q_req = 1'b0;
  logic          q_we  = 1'b0;
  logic [AW-1:0] q_addr;
  logic [3:0]    q_be;
  logic [31:0]   q_wd;
  int            ntx;
  logic [AW-1:0] a_log [2];
  logic [3:0]    be_log [2];

  always begin
    @(negedge clk);
    #1;
    q_req  = mem_req;
    q_we   = mem_we;
    q_addr = mem_addr;
    q_be   = mem_be;
    q_wd   = mem_wdata;
    if (mem_req) begin
      if (ntx < 2) begin
        a_log[ntx]  = mem_addr;
        be_log[ntx] = mem_be;
      end
      ntx++;
    end
  end

  always @(posedge clk) begin
    if (q_req) begin
      if (q_we) begin
        for (int k = 0; k < 4; k++)
          if (q_be[k]) mem[q_addr[5:2]][k*8 +: 8] <= q_wd[k*8 +: 8];
      end else begin
        mem_rdata <= mem[q_addr[5:2]];
      end
    end
  end

  function automatic logic [7:0] pat(input int x);
    return 8'(x) | {x[0], 7'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [1:0] kd,
                        input logic sg, input logic a, input logic u,
                        input logic [AW-1:0] ad, input logic [31:0] wd,
                        output int lat, output logic f, output logic [3:0] fc,
                        output logic [31:0] rd);
    @(negedge clk);
    req_write = wr; req_size = sz; req_kind = kd; req_signed = sg;
    cfg_strict = a; cfg_unaligned = u; req_addr = ad; req_wdata = wd;
    ntx = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    f  = fault;
    fc = fault_code;
    rd = rdata;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  size;
    logic [1:0]  kind;
    logic        sgn;
    logic        a;
    logic        u;
    logic [5:0]  addr;
    logic        flt;
    logic [1:0]  txn;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd9,  2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 2'd1, 32'h83028100}, // R9 aligned word
    '{4'd3,  2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 6'd5,  1'b0, 2'd1, 32'h04870685}, // R3 rotate 8
    '{4'd3,  2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 6'd6,  1'b0, 2'd1, 32'h85048706}, // R3 rotate 16
    '{4'd4,  2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd3,  1'b0, 2'd1, 32'h00008302}, // R4 bit0 ignored
    '{4'd8,  2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd3,  1'b0, 2'd1, 32'hFFFF8302}, // R8 sign ext
    '{4'd9,  2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 6'd5,  1'b0, 2'd1, 32'h00000685}, // R9 inner half
    '{4'd5,  2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 6'd7,  1'b0, 2'd2, 32'h00000887}, // R5 split half
    '{4'd7,  2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 6'd6,  1'b0, 2'd2, 32'h89088706}, // R7 split word
    '{4'd7,  2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 6'd3,  1'b0, 2'd2, 32'h06850483}, // R7 split word
    '{4'd1,  2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 6'd1,  1'b1, 2'd0, 32'h00000000}, // R1 word, A=1 U=1
    '{4'd1,  2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 6'd9,  1'b1, 2'd0, 32'h00000000}, // R1 odd half
    '{4'd1,  2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 6'd2,  1'b1, 2'd0, 32'h00000000}, // R1 word off 2
    '{4'd2,  2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 6'd4,  1'b0, 2'd1, 32'h87068504}, // R2 aligned multiple
    '{4'd2,  2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 6'd6,  1'b1, 2'd0, 32'h00000000}, // R2 doubleword
    '{4'd2,  2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd1,  1'b1, 2'd0, 32'h00000000}, // R2 exclusive, size ignored
    '{4'd10, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 6'd7,  1'b0, 2'd1, 32'h00000087}, // R10 byte
    '{4'd8,  2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 6'd9,  1'b0, 2'd1, 32'hFFFFFF89}, // R8 signed byte
    '{4'd9,  2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 6'd2,  1'b0, 2'd1, 32'h00008302}, // R9 half no cross
    '{4'd10, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 6'd4,  1'b0, 2'd1, 32'h00008504}, // R10 aligned half
    '{4'd8,  2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 2'd1, 32'hFFFF8100}, // R8
    '{4'd10, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 6'd4,  1'b0, 2'd1, 32'h87068504}, // R10 aligned exclusive
    '{4'd1,  2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 6'd5,  1'b1, 2'd0, 32'h00000000}, // R1 multiple, strict
    '{4'd7,  2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 6'd13, 1'b0, 2'd2, 32'h108F0E8D}, // R7 split word
    '{4'd2,  2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 6'd5,  1'b0, 2'd1, 32'h04870685}  // R2 legacy multiple
  };

  int          lat;
  logic        f;
  logic [3:0]  fc;
  logic [31:0] rd;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_kind = 2'd0;
    req_signed = 1'b0; cfg_strict = 1'b0; cfg_unaligned = 1'b0;
    req_addr = '0; req_wdata = '0; ntx = 0;
    for (int i = 0; i < 16; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};

    // R11: reset state
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready in reset", 32'(req_ready), 32'd1);
    chk(done === 1'b0 && fault === 1'b0, "R11", "done/fault in reset", 32'({done, fault}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0, "R11", "idle after reset",
        32'({req_ready, mem_req, done}), 32'b100);

    // load table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string r;
      v = VECS[i];
      r = $sformatf("R%0d vec%0d", v.req, i);
      access(1'b0, v.size, v.kind, v.sgn, v.a, v.u, AW'(v.addr), 32'b0, lat, f, fc, rd);
      chk(lat == ((v.txn == 2'd2) ? 2 : 1), r, "latency", 32'(lat), (v.txn == 2'd2) ? 32'd2 : 32'd1);
      chk(f == v.flt, r, "fault", 32'(f), 32'(v.flt));
      chk(ntx == int'(v.txn), r, "transactions", 32'(ntx), 32'(v.txn));
      if (v.flt) chk(fc == 4'b0001, r, "fault code", 32'(fc), 32'h1);
      else begin
        chk(rd == v.data, r, "load data", rd, v.data);
        chk(a_log[0] == {AW'(v.addr) >> 2, 2'b00}, r, "first address",
            32'(a_log[0]), 32'({AW'(v.addr) >> 2, 2'b00}));
      end
    end

    // R6: split word store at 6
    access(1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, AW'(6), 32'hDDCCBBAA, lat, f, fc, rd);
    chk(ntx == 2, "R6", "store transactions", 32'(ntx), 32'd2);
    chk(be_log[0] == 4'b1100 && be_log[1] == 4'b0011, "R6", "byte enables",
        32'({be_log[0], be_log[1]}), 32'h000000C3);
    chk(a_log[1] == AW'(8), "R5", "second address", 32'(a_log[1]), 32'd8);
    chk(mem[1] == 32'hBBAA8504, "R6", "word1", mem[1], 32'hBBAA8504);
    chk(mem[2] == 32'h8B0ADDCC, "R6", "word2", mem[2], 32'h8B0ADDCC);

    // R4: legacy halfword store at 13 lands at 12
    access(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, AW'(13), 32'h00001234, lat, f, fc, rd);
    chk(be_log[0] == 4'b0011 && ntx == 1, "R4", "legacy half be", 32'(be_log[0]), 32'h3);
    chk(mem[3] == 32'h8F0E1234, "R4", "word3", mem[3], 32'h8F0E1234);

    // R1: faulting store leaves memory untouched
    access(1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, AW'(1), 32'h0000FFFF, lat, f, fc, rd);
    chk(f == 1'b1 && ntx == 0, "R1", "store fault no txn", 32'({f, 4'(ntx)}), 32'h10);
    chk(mem[0] == 32'h83028100, "R1", "word0 unchanged", mem[0], 32'h83028100);

    // R6: split halfword store at 3
    access(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, AW'(3), 32'h00005566, lat, f, fc, rd);
    chk(be_log[0] == 4'b1000 && be_log[1] == 4'b0001 && lat == 2, "R6", "half split be",
        32'({be_log[0], be_log[1]}), 32'h00000081);
    chk(mem[0] == 32'h66028100, "R6", "word0", mem[0], 32'h66028100);
    chk(mem[1] == 32'hBBAA8555, "R6", "word1 after half", mem[1], 32'hBBAA8555);

    // R9: byte store, one transaction
    access(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, AW'(10), 32'h000000AB, lat, f, fc, rd);
    chk(ntx == 1 && be_log[0] == 4'b0100 && lat == 1, "R9", "byte store",
        32'({4'(ntx), be_log[0]}), 32'h14);
    chk(mem[2] == 32'h8BABDDCC, "R9", "word2 byte", mem[2], 32'h8BABDDCC);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule